// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a memory-mapped watchdog timer. While enabled, it divides its clock by a fixed prescaler and counts the resulting ticks up to a terminal count of two to the power of a postscaler value. The postscaler value is fixed by a static configuration input. At the terminal count it emits a one-cycle reset request and records the event in a sticky status register. It then wraps to zero and keeps running.

Software keeps the system alive by writing a 16-bit key into the upper halfword of the control register. Any other value, or a write of any other width, leaves the count alone. The enable bit cannot be changed by a plain write. It is set through a set-alias address and cleared through a clear-alias address. For one cycle after a disable, the register port ignores every access.

The control word also shows three values, all driven by static configuration inputs: the postscaler field, the clock-select field and a windowed-clear status bit.

Top module: `kwdt_top`

## Requirements
- R1: Control word layout. Bit 15 is the enable (0 after reset). Bits 12:8 are the postscaler input, bits 7:6 are the clock-select input and bit 0 is the window-mode input. Every other bit reads 0, and software writes never change the three configuration fields.
- R2: Word addresses 0, 1 and 2 are the control register's plain, set-alias and clear-alias views. A write to address 1 with byte lane 1 enabled and data bit 15 at 1 sets the enable. The same write to address 2 clears it. A write to address 0 never changes the enable.
- R3: After the set-alias write that enables the block, the first reset request appears 32·2^PS clock cycles after that write's sampling edge. It lasts exactly one cycle.
- R4: After each reset request, the count restarts from zero. The next request follows exactly 32·2^PS cycles after the previous one.
- R5: A write to address 0 with byte enables exactly 4'b1100 and data bits 31:16 equal to 0x5743 restarts the prescaler and the counter. The next request then comes a full 32·2^PS cycles after that write.
- R6: A control write with a different key value, with other byte enables, or to an alias address leaves the count unchanged.
- R7: Clearing the enable stops the count and resets both the prescaler and the counter. No request is raised while disabled. A later enable starts a full period.
- R8: In the cycle right after a clear-alias write that turns the enable off, every access is ignored and every read returns 0.
- R9: Word addresses 4 and 6 are the status register's plain and clear views. Status bit 4 is set at each reset request and stays set. It is cleared only by a write to address 6 with byte lane 0 enabled and data bit 4 at 1. Writes to address 4 are ignored. A new timeout in the same cycle wins over a clear.
- R10: Status bit 2 is set at a reset request raised while the idle input is high, and status bit 3 at one raised while the sleep input is high. Each is cleared in the same way as bit 4, using data bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_en | input | 1 | Static window-mode status, read back at control bit 0 |
| cfg_post | input | PS_W | Static postscaler exponent PS |
| cfg_clk_sel | input | 2 | Static clock-select value, read back at control bits 7:6 |
| sys_idle | input | 1 | System is idle |
| sys_sleep | input | 1 | System is asleep |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| wdt_reset_req | output | 1 | One-cycle reset request at terminal count |

## Verification
The bench measures exact cycle distances from enable, key write and disable to the reset request. A design that left the prescaler running across a key write or a disable would be caught by a period that comes out short by up to 31 cycles. A late or stretched pulse would show up as an off-by-one count or a second high cycle. Near-miss keys are sent partway through a period: a wrong value, a full-word write and a single-byte write. A decoder that is too loose restarts the period and moves the pulse late. The cycle right after a disable gets both a read and an enable attempt. A design without the lockout returns data or re-enables itself. The status flags are set, then hit with plain writes and partial clears, which exposes flags that are not sticky or that clear together.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // Low two bits of the word address select the view of a register
   typedef enum logic [1:0] {
      VIEW_PLAIN = 2'd0,
      VIEW_SET   = 2'd1,
      VIEW_CLR   = 2'd2,
      VIEW_NONE  = 2'd3
   } view_e;

   // Upper address bits select the register
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_STAT = 1;

   // Fixed bit positions of the control and status words
   localparam int unsigned CTRL_ON_BIT   = 15;
   localparam int unsigned CTRL_PS_LSB   = 8;
   localparam int unsigned CTRL_SEL_LSB  = 6;
   localparam int unsigned CTRL_WIN_BIT  = 0;
   localparam int unsigned STAT_IDLE_BIT = 2;

   localparam logic [3:0] KEY_LANES = 4'b1100;

endpackage

// File: rtl/kwdt_count.sv
module kwdt_count #(
   parameter int unsigned PRESCALE = 32,
   parameter int unsigned PS_W     = 5,
   parameter int unsigned CNT_W    = 31
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] ps,
   output logic            term_hit,
   output logic            fire_q
);

   localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             at_limit;

   generate
      if (PRESCALE > 1) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         assign tick = run && (pre_q == PRE_W'(PRESCALE - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (!run || restart)
               pre_q <= '0;
            else if (tick)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
      end else begin : g_nopre
         assign tick = run;
      end
   endgenerate

   assign limit    = CNT_W'((64'd1 << ps) - 64'd1);
   assign at_limit = (cnt_q == limit);
   assign term_hit = run && !restart && tick && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || restart)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fire_q <= 1'b0;
      else
         fire_q <= term_hit;
   end

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PS_W   = 5,
   parameter logic [15:0] KEY    = 16'h5743
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_win_en,
   input  logic [PS_W-1:0]   cfg_post,
   input  logic [1:0]        cfg_clk_sel,
   input  logic              sys_idle,
   input  logic              sys_sleep,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              term_hit,
   output logic              on_q,
   output logic              lock_q,
   output logic              key_hit,
   output logic [2:0]        flags_q,
   output logic [2:0]        flag_clr
);

   logic        acc_ok;
   logic        wr_ok;
   logic        is_ctrl;
   logic        is_stat;
   view_e       view;
   logic        set_hit;
   logic        clr_hit;
   logic [31:0] ctrl_word;
   logic [31:0] stat_word;
   logic        unused_wdata;

   assign unused_wdata = ^{bus_wdata[14:5], bus_wdata[1:0]};

   assign acc_ok  = bus_valid && !lock_q;
   assign wr_ok   = acc_ok && bus_write;
   assign is_ctrl = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(REG_CTRL));
   assign is_stat = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(REG_STAT));
   assign view    = view_e'(bus_addr[1:0]);

   assign set_hit = wr_ok && is_ctrl && (view == VIEW_SET) &&
                    bus_be[1] && bus_wdata[CTRL_ON_BIT];
   assign clr_hit = wr_ok && is_ctrl && (view == VIEW_CLR) &&
                    bus_be[1] && bus_wdata[CTRL_ON_BIT];
   assign key_hit = wr_ok && is_ctrl && (view == VIEW_PLAIN) &&
                    (bus_be == KEY_LANES) && (bus_wdata[31:16] == KEY);

   assign flag_clr = (wr_ok && is_stat && (view == VIEW_CLR) && bus_be[0]) ?
                     bus_wdata[STAT_IDLE_BIT +: 3] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         if (set_hit)
            on_q <= 1'b1;
         else if (clr_hit)
            on_q <= 1'b0;
         lock_q <= on_q && clr_hit;
      end
   end

   // flags_q = {timeout, sleep-timeout, idle-timeout}; a timeout wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= 3'b000;
      else
         flags_q <= (flags_q & ~flag_clr) |
                    (term_hit ? {1'b1, sys_sleep, sys_idle} : 3'b000);
   end

   always_comb begin
      ctrl_word                        = '0;
      ctrl_word[CTRL_ON_BIT]           = on_q;
      ctrl_word[CTRL_PS_LSB +: PS_W]   = cfg_post;
      ctrl_word[CTRL_SEL_LSB +: 2]     = cfg_clk_sel;
      ctrl_word[CTRL_WIN_BIT]          = cfg_win_en;
      stat_word                        = '0;
      stat_word[STAT_IDLE_BIT +: 3]    = flags_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (acc_ok && !bus_write && (view != VIEW_NONE)) begin
         if (is_ctrl)
            bus_rdata = ctrl_word;
         else if (is_stat)
            bus_rdata = stat_word;
      end
   end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned PS_W     = 5,
   parameter int unsigned PRESCALE = 32,
   parameter logic [15:0] KEY      = 16'h5743
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_win_en,
   input  logic [PS_W-1:0]   cfg_post,
   input  logic [1:0]        cfg_clk_sel,
   input  logic              sys_idle,
   input  logic              sys_sleep,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdt_reset_req
);

   // Counter must hold 2^(2^PS_W - 1) - 1
   localparam int unsigned CNT_W = (1 << PS_W) - 1;

   generate
      if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
         $error("kwdt_top: PS_W must lie in 1..5 to fit control bits 12:8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("kwdt_top: ADDR_W must be at least 3");
      end
      if (PRESCALE == 0 || (PRESCALE & (PRESCALE - 1)) != 0) begin : g_bad_pre
         $error("kwdt_top: PRESCALE must be a power of two");
      end
   endgenerate

   logic       on_q;
   logic       lock_q;
   logic       key_hit;
   logic       term_hit;
   logic [2:0] flags_q;
   logic [2:0] flag_clr;

   kwdt_regs #(
      .ADDR_W (ADDR_W),
      .PS_W   (PS_W),
      .KEY    (KEY)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_win_en  (cfg_win_en),
      .cfg_post    (cfg_post),
      .cfg_clk_sel (cfg_clk_sel),
      .sys_idle    (sys_idle),
      .sys_sleep   (sys_sleep),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_be      (bus_be),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .term_hit    (term_hit),
      .on_q        (on_q),
      .lock_q      (lock_q),
      .key_hit     (key_hit),
      .flags_q     (flags_q),
      .flag_clr    (flag_clr)
   );

   kwdt_count #(
      .PRESCALE (PRESCALE),
      .PS_W     (PS_W),
      .CNT_W    (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (on_q),
      .restart  (key_hit),
      .ps       (cfg_post),
      .term_hit (term_hit),
      .fire_q   (wdt_reset_req)
   );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        on_q,
   input logic        lock_q,
   input logic        fire,
   input logic [2:0]  flags_q,
   input logic [2:0]  flag_clr,
   input logic [31:0] rdata
);

   // R3
   fire_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   // R7
   fire_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(on_q));

   // R9
   flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> flags_q[2]);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q[2]) |-> $past(flag_clr[2]));

   // R8
   lock_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> (rdata == 32'h0));

   // R8
   lock_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> (!on_q && $past(on_q)));

endmodule

bind kwdt_top kwdt_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .on_q     (on_q),
   .lock_q   (lock_q),
   .fire     (wdt_reset_req),
   .flags_q  (flags_q),
   .flag_clr (flag_clr),
   .rdata    (bus_rdata)
);

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_win_en = 1'b1;
   logic [4:0]  cfg_post = 5'd0;
   logic [1:0]  cfg_clk_sel = 2'b10;
   logic        sys_idle = 1'b0;
   logic        sys_sleep = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_reset_req;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;   // 125 MHz

   kwdt_top dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_win_en (cfg_win_en), .cfg_post (cfg_post), .cfg_clk_sel (cfg_clk_sel),
      .sys_idle (sys_idle), .sys_sleep (sys_sleep),
      .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
      .bus_be (bus_be), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .wdt_reset_req (wdt_reset_req)
   );

   function automatic logic [31:0] fields(input logic [4:0] ps);
      return 32'h1 | (32'(cfg_clk_sel) << 6) | (32'(ps) << 8);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
      #2 d = bus_rdata;
      @(posedge clk);
      #1 bus_valid = 1'b0;
   endtask

   task automatic wdt_on();
      wr(3'd1, 4'b0010, 32'h0000_8000);
   endtask

   task automatic wdt_off();
      wr(3'd2, 4'b0010, 32'h0000_8000);
      @(negedge clk);   // let the lockout cycle pass
   endtask

   // counts negedges until the reset request is seen
   task automatic measure(output int n);
      n = 0;
      for (int i = 1; i <= 10000; i++) begin
         @(negedge clk);
         if (wdt_reset_req) begin n = i; break; end
      end
   endtask

   task automatic quiet(input int cyc, output int seen);
      seen = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (wdt_reset_req) seen++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(3'd0, d); chk("R1 reset ctrl", d, fields(5'd0));
      rd(3'd4, d); chk("R9 reset status", d, 32'h0);
      chk("R3 reset request low", 32'(wdt_reset_req), 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      wr(3'd1, 4'hF, 32'hFFFF_FFFF);
      rd(3'd0, d); chk("R1 fields ignore writes", d, 32'h8000 | fields(5'd0));
      wr(3'd2, 4'b0011, 32'h0000_8000);
      rd(3'd0, d); chk("R8 read in lockout", d, 32'h0);
      rd(3'd0, d); chk("R2 clear alias disables", d, fields(5'd0));
   endtask

   task automatic t_plain();
      logic [31:0] d;
      int seen;
      wr(3'd0, 4'hF, 32'h0000_8000);
      rd(3'd0, d); chk("R2 plain write keeps enable off", d, fields(5'd0));
      quiet(60, seen); chk("R7 no request while disabled", 32'(seen), 32'h0);
   endtask

   task automatic t_period(input logic [4:0] ps);
      int n;
      cfg_post = ps;
      wdt_on();
      measure(n); chk("R3 first timeout", 32'(n), (32'd32 << ps) + 1);
      @(negedge clk); chk("R3 single-cycle pulse", 32'(wdt_reset_req), 32'h0);
      measure(n); chk("R4 wrap period", 32'(n), (32'd32 << ps) - 1);
      wdt_off();
   endtask

   task automatic t_key();
      int n;
      cfg_post = 5'd1;
      wdt_on();
      repeat (39) @(negedge clk);
      wr(3'd0, 4'b1100, 32'h5743_0000);
      measure(n); chk("R5 key restarts full period", 32'(n), 32'd65);
      wdt_off();
   endtask

   task automatic t_badkey();
      int n;
      logic [2:0]  a  [3] = '{3'd0, 3'd0, 3'd1};
      logic [3:0]  be [3] = '{4'b1100, 4'b1111, 4'b1100};
      logic [31:0] dv [3] = '{32'h5744_0000, 32'h5743_0000, 32'h5743_0000};
      cfg_post = 5'd1;
      for (int k = 0; k < 3; k++) begin
         wdt_on();
         repeat (39) @(negedge clk);
         wr(a[k], be[k], dv[k]);
         measure(n); chk($sformatf("R6 ignored key variant %0d", k), 32'(n), 32'd25);
         wdt_off();
      end
      wdt_on();
      repeat (39) @(negedge clk);
      wr(3'd0, 4'b0100, 32'h5743_0000);
      measure(n); chk("R6 byte-wide key ignored", 32'(n), 32'd25);
      wdt_off();
   endtask

   task automatic t_restart();
      int n, seen;
      cfg_post = 5'd1;
      wdt_on();
      repeat (39) @(negedge clk);
      wdt_off();
      quiet(80, seen); chk("R7 disabled stays silent", 32'(seen), 32'h0);
      wdt_on();
      measure(n); chk("R7 re-enable full period", 32'(n), 32'd65);
      wdt_off();
   endtask

   task automatic t_lock();
      logic [31:0] d;
      cfg_post = 5'd0;
      wdt_on();
      wr(3'd2, 4'b0010, 32'h0000_8000);
      wr(3'd1, 4'b0010, 32'h0000_8000);   // lands in the lockout cycle
      rd(3'd0, d); chk("R8 write in lockout ignored", d, fields(5'd0));
   endtask

   task automatic t_status();
      logic [31:0] d;
      int n;
      cfg_post = 5'd0;
      wr(3'd6, 4'b0001, 32'h0000_001C);
      rd(3'd4, d); chk("R9 status cleared", d, 32'h0);
      sys_idle = 1'b1;
      wdt_on();
      measure(n);
      wdt_off();
      sys_idle = 1'b0;
      rd(3'd4, d); chk("R10 idle timeout flag", d, 32'h14);
      wr(3'd4, 4'hF, 32'h0);
      rd(3'd4, d); chk("R9 plain status write ignored", d, 32'h14);
      wr(3'd6, 4'b0001, 32'h0000_0010);
      rd(3'd4, d); chk("R9 clear bit 4 only", d, 32'h04);
      wr(3'd6, 4'b0001, 32'h0000_0004);
      rd(3'd4, d); chk("R10 clear idle flag", d, 32'h0);
      sys_sleep = 1'b1;
      wdt_on();
      measure(n);
      wdt_off();
      sys_sleep = 1'b0;
      rd(3'd4, d); chk("R10 sleep timeout flag", d, 32'h18);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_plain();
      t_period(5'd0);
      t_period(5'd2);
      t_key();
      t_badkey();
      t_restart();
      t_lock();
      t_status();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule